// File: doc/BRIEF.md
# Hierarchical Ping-Pong Tree Arbiter

This block picks one winner among up to sixteen request lines. It is built as a two-layer tree of 4-input cells: four leaf cells and one root cell. Each cell is itself three 2-input nodes. Two nodes each judge a pair of inputs, and a third node judges between the two pairs. Every node keeps a single preference bit. When both of its sides request, the preferred side wins. After the node passes a grant down, the preference moves to the side that did not win. This alternation gives fairness without a central pointer.

Requests travel upward as an OR through the tree to `grp_req_o`. The decision travels downward as a grant, gated at every node, starting from `grp_gnt_i`. This lets the whole arbiter act as one cell in a larger tree: a parent sees the group request and answers with the group grant. A standalone user ties `grp_gnt_i` high.

The request and grant lines are level-sensitive control signals that are judged every cycle. There is no data path, so there is no valid/ready stream. A grant counts as accepted in a cycle when `grp_gnt_i` is high. Node preferences change only on that clock edge. A low `grp_gnt_i` therefore acts as back-pressure: it freezes the fairness state and withholds every grant. Reset is synchronous and active high.

Top module: `pingpong_tree_arb`

## Requirements
- R1: `grp_req_o` is high in the same cycle exactly when at least one bit of `req_i` is high.
- R2: At most one bit of `gnt_o` is high in any cycle.
- R3: `gnt_o[i]` is high only when `req_i[i]` is high and `grp_gnt_i` is high. When `grp_gnt_i` is low or no input requests, `gnt_o` is all zero.
- R4: When `grp_gnt_i` is high and at least one input requests, exactly one bit of `gnt_o` is high in that cycle.
- R5: Each 2-input node (pairs {2k, 2k+1}, then pairs of pairs, then halves 0–7 versus 8–15) gives a sole requesting side the grant. When both sides request, the side named by its preference bit wins.
- R6: On the clock edge after a node forwards a grant, its preference points to the side that did not win. A node that forwards no grant keeps its preference. As a result, two contending inputs 0 and 1 alone are granted 0, 1, 0 in successive accepted cycles.
- R7: A synchronous reset sets every preference to the lower-indexed side. In the first accepted cycle after reset with all sixteen inputs requesting, `gnt_o` is 16'h0001.
- R8: With `grp_gnt_i` high, an input that keeps requesting sees at most 15 grants go to other inputs before it is granted.
- R9: Cycles with `grp_gnt_i` low leave all preferences unchanged. After such cycles, the next accepted grant is the one that would have been issued without them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; preferences update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 16 | Request lines, one per input, level-sensitive |
| grp_gnt_i | input | 1 | Grant from the parent layer; tie high for standalone use |
| gnt_o | output | 16 | One-hot-or-zero grant, combinational from the requests and the preferences |
| grp_req_o | output | 1 | Group request toward the parent layer |

## Verification
The bench runs a behavioural model of the tree: a heap of preference bits walked from the root by halving the input range. It compares every cycle against that model. It targets several corner cases, each with the failure it would expose:
- Two inputs in the same pair contending. A node that never flips would starve input 1.
- A node flipping when its grant is withheld by a low `grp_gnt_i`. The first grant after the stall would then come out wrong.
- A sole requester whose preference points the other way. A wrong gate would lose the grant or send it to an idle line.
- Long runs with random contention and every input held on. The 15-grant bound would be broken by a node that flips on a request alone or that forgets to flip on an uncontested grant.

// File: rtl/pp_arb_pkg.sv
package pp_arb_pkg;

  typedef enum logic {
    PREF_LO = 1'b0,
    PREF_HI = 1'b1
  } pref_e;

  // Bit offset of tree level l inside the flattened per-level vector.
  function automatic int lvl_off(input int n_in, input int l);
    int s;
    s = 0;
    for (int k = 0; k < l; k++) s += (n_in >> (2 * k));
    return s;
  endfunction

  // Number of signals at tree level l (level 0 = the inputs).
  function automatic int lvl_width(input int n_in, input int l);
    return n_in >> (2 * l);
  endfunction

endpackage

// File: rtl/pp_node.sv
module pp_node
  import pp_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_lo,
  input  logic req_hi,
  input  logic gnt_in,
  output logic any_req,
  output logic gnt_lo,
  output logic gnt_hi
);

  pref_e pref;
  logic  pick_hi;

  assign any_req = req_lo | req_hi;
  assign pick_hi = req_hi & (~req_lo | (pref == PREF_HI));
  assign gnt_hi  = gnt_in & pick_hi;
  assign gnt_lo  = gnt_in & req_lo & ~pick_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      pref <= PREF_LO;
    end else if (gnt_in && any_req) begin
      pref <= pick_hi ? PREF_LO : PREF_HI;
    end
  end

  // R2: a node never grants both sides
  p_pair_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(gnt_lo && gnt_hi));

  // R5: a sole requester wins whenever the parent grants
  p_single_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (gnt_in && req_lo && !req_hi) |-> gnt_lo);

  // R6: preference moves to the losing side after a forwarded grant
  p_pref_moves_lo_r6: assert property (@(posedge clk) disable iff (rst)
    gnt_lo |=> (pref == PREF_HI));
  p_pref_moves_hi_r6: assert property (@(posedge clk) disable iff (rst)
    gnt_hi |=> (pref == PREF_LO));

  // R6, R9: no forwarded grant, no change
  p_pref_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(gnt_lo || gnt_hi) |=> $stable(pref));

  // R7: reset favours the lower side
  p_reset_pref_r7: assert property (@(posedge clk)
    rst |=> (pref == PREF_LO));

endmodule

// File: rtl/pp_quad_cell.sv
module pp_quad_cell (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] req,
  input  logic       gnt_in,
  output logic [3:0] gnt,
  output logic       any_req
);

  logic [1:0] pair_any;
  logic [1:0] pair_gnt;

  for (genvar p = 0; p < 2; p++) begin : g_pair
    pp_node u_pair (
      .clk    (clk),
      .rst    (rst),
      .req_lo (req[2*p]),
      .req_hi (req[2*p+1]),
      .gnt_in (pair_gnt[p]),
      .any_req(pair_any[p]),
      .gnt_lo (gnt[2*p]),
      .gnt_hi (gnt[2*p+1])
    );
  end

  pp_node u_join (
    .clk    (clk),
    .rst    (rst),
    .req_lo (pair_any[0]),
    .req_hi (pair_any[1]),
    .gnt_in (gnt_in),
    .any_req(any_req),
    .gnt_lo (pair_gnt[0]),
    .gnt_hi (pair_gnt[1])
  );

  // R3: cell grants only its own requesters and only under a parent grant
  p_cell_gnt_r3: assert property (@(posedge clk) disable iff (rst)
    ((gnt & ~req) == 4'b0) && (gnt_in || (gnt == 4'b0)));

endmodule

// File: rtl/pingpong_tree_arb.sv
module pingpong_tree_arb
  import pp_arb_pkg::*;
#(
  parameter  int LEVELS = 2,
  localparam int N_IN   = 4 ** LEVELS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] req_i,
  input  logic            grp_gnt_i,
  output logic [N_IN-1:0] gnt_o,
  output logic            grp_req_o
);

  localparam int TOTAL = lvl_off(N_IN, LEVELS + 1);

  // All levels flattened: level 0 = inputs, level LEVELS = the single group line.
  logic [TOTAL-1:0] tr_req;
  logic [TOTAL-1:0] tr_gnt;

  assign tr_req[N_IN-1:0] = req_i;
  assign gnt_o            = tr_gnt[N_IN-1:0];
  assign grp_req_o        = tr_req[TOTAL-1];
  assign tr_gnt[TOTAL-1]  = grp_gnt_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int OFF_IN  = lvl_off(N_IN, l);
    localparam int OFF_OUT = lvl_off(N_IN, l + 1);
    localparam int N_CELL  = lvl_width(N_IN, l + 1);
    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
      pp_quad_cell u_cell (
        .clk    (clk),
        .rst    (rst),
        .req    (tr_req[OFF_IN + 4*c +: 4]),
        .gnt_in (tr_gnt[OFF_OUT + c]),
        .gnt    (tr_gnt[OFF_IN + 4*c +: 4]),
        .any_req(tr_req[OFF_OUT + c])
      );
    end
  end

  // R1: group request reflects any input request
  p_grp_req_r1: assert property (@(posedge clk) disable iff (rst)
    grp_req_o == (req_i != '0));

  // R2: one-hot-or-zero grant vector
  p_onehot_gnt_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));

  // R3: grants only to requesters, and only under the group grant
  p_gnt_to_req_r3: assert property (@(posedge clk) disable iff (rst)
    (gnt_o & ~req_i) == '0);
  p_no_gnt_wo_parent_r3: assert property (@(posedge clk) disable iff (rst)
    !grp_gnt_i |-> (gnt_o == '0));

  // R4: a granted group with requests yields exactly one grant
  p_one_when_granted_r4: assert property (@(posedge clk) disable iff (rst)
    (grp_gnt_i && (req_i != '0)) |-> ($countones(gnt_o) == 1));

endmodule

// File: tb/pingpong_tree_arb_tb.sv
module pingpong_tree_arb_tb;
  localparam int LEVELS = 2;
  localparam int N      = 4 ** LEVELS;
  localparam int MAXW   = 15;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] req;
  logic         gg;
  logic [N-1:0] gnt;
  logic         greq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit pref [2*N];
  int waitc [N];

  always #5 clk = ~clk;

  pingpong_tree_arb #(.LEVELS(LEVELS)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req),
    .grp_gnt_i(gg),
    .gnt_o    (gnt),
    .grp_req_o(greq)
  );

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit range_any(input logic [N-1:0] r, input int lo, input int sz);
    for (int j = lo; j < lo + sz; j++) if (r[j]) return 1'b1;
    return 1'b0;
  endfunction

  // Walk from the root, halving the input range; optionally move preferences.
  function automatic logic [N-1:0] model(input logic [N-1:0] r, input bit g, input bit upd);
    logic [N-1:0] one;
    int k, lo, sz, half;
    bit a_lo, a_hi, hi;
    one = '0;
    one[0] = 1'b1;
    if (!g || r == '0) return '0;
    k = 1; lo = 0; sz = N;
    while (sz > 1) begin
      half = sz / 2;
      a_lo = range_any(r, lo, half);
      a_hi = range_any(r, lo + half, half);
      hi = a_hi && (!a_lo || pref[k]);
      if (upd) pref[k] = !hi;
      k = 2 * k + int'(hi);
      if (hi) lo += half;
      sz = half;
    end
    return one << lo;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2*N; i++) pref[i] = 1'b0;
    for (int i = 0; i < N; i++) waitc[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req = '0; gg = 1'b0;
    #1;
    chk(gnt == '0 && greq == 1'b0, "R7 outputs idle in reset", gnt, '0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic step(input logic [N-1:0] r, input bit g, output logic [N-1:0] got);
    logic [N-1:0] exp;
    int worst;
    @(negedge clk);
    req = r; gg = g;
    #1;
    got = gnt;
    exp = model(r, g, 1'b0);
    chk(greq == (r != '0), "R1 group request", {{(N-1){1'b0}}, greq},
        {{(N-1){1'b0}}, (r != '0)});
    chk($onehot0(gnt), "R2 grant one-hot", gnt, exp);
    chk((gnt & ~r) == '0 && (g || gnt == '0), "R3 grant to requester only", gnt, exp);
    chk(gnt == exp, "R5/R6 grant vs model", gnt, exp);
    worst = 0;
    for (int i = 0; i < N; i++) begin
      if (!r[i] || gnt[i]) waitc[i] = 0;
      else if (g && gnt != '0) waitc[i]++;
      if (waitc[i] > worst) worst = waitc[i];
    end
    chk(worst <= MAXW, "R8 wait bound", N'(worst), N'(MAXW));
    void'(model(r, g, 1'b1));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] g;
    logic [N-1:0] r;
    rst = 1'b1; req = '0; gg = 1'b0;
    model_reset();
    do_reset();

    // R7: first grant after reset with all requesting
    step('1, 1'b1, g);
    chk(g == 16'h0001, "R7 first grant after reset", g, 16'h0001);
    for (int i = 0; i < 40; i++) step('1, 1'b1, g);

    // R6: two contenders in one pair alternate
    do_reset();
    step(16'h0003, 1'b1, g); chk(g == 16'h0001, "R6 alternate 1st", g, 16'h0001);
    step(16'h0003, 1'b1, g); chk(g == 16'h0002, "R6 alternate 2nd", g, 16'h0002);
    step(16'h0003, 1'b1, g); chk(g == 16'h0001, "R6 alternate 3rd", g, 16'h0001);

    // R5: sole requester always wins, whatever the preferences
    for (int i = 0; i < 3; i++) begin
      step(16'h0100, 1'b1, g);
      chk(g == 16'h0100, "R5 sole requester", g, 16'h0100);
    end

    // R3, R4: no grant without the group grant, exactly one with it
    step(16'hA5A5, 1'b0, g); chk(g == '0, "R3 withheld group grant", g, '0);
    step(16'hA5A5, 1'b1, g); chk($countones(g) == 1, "R4 exactly one grant", g, '0);
    step('0, 1'b1, g);       chk(g == '0, "R3 no request", g, '0);

    // R9: stalled cycles leave state untouched
    do_reset();
    for (int i = 0; i < 5; i++) step('1, 1'b0, g);
    step('1, 1'b1, g); chk(g == 16'h0001, "R9 state frozen while withheld", g, 16'h0001);
    step('1, 1'b1, g); chk(g == 16'h0100, "R9 next grant after stall", g, 16'h0100);

    // Held random subsets: R8 under sustained contention
    for (int b = 0; b < 30; b++) begin
      r = N'($urandom);
      for (int i = 0; i < 40; i++) step(r, 1'b1, g);
    end

    // Fully random traffic with random back-pressure
    for (int i = 0; i < 2000; i++) begin
      r = N'($urandom) & N'($urandom);
      step(r, ($urandom % 5) != 0, g);
    end

    // Mid-run reset then R7 again
    do_reset();
    step('1, 1'b1, g);
    chk(g == 16'h0001, "R7 grant after mid-run reset", g, 16'h0001);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule